// File: doc/BRIEF.md
# Synchronous PSRAM-style write slave

This block sits on the FPGA side of a synchronous external memory bus that a microcontroller drives as if it were a PSRAM. The bus has a clock that never stops, an active-low chip select, an active-low address strobe, separate address lines and a 16-bit data bus. When the strobe and the chip select are both low on a clock edge, the slave latches the address. It waits a fixed latency and then takes one data beat on each rising edge. It pairs the beats into 32-bit words and stores each word in a small register file.

The microcontroller may leave the chip select low for more than one word. The slave therefore keeps pairing beats and advancing the word index until the chip select goes high, wrapping around the end of the file. If the select goes high halfway through a word, that half word is dropped and an error counter steps. A one-cycle done pulse, carrying the index, reports each stored word. A combinational read port lets the fabric read any entry.

Top module: `psram_wr_slave`

## Requirements
- R1: While rst_n is low and right after its release, every register-file entry reads 0, err_count is 0 and wr_done is 0.
- R2: An access starts on a rising edge where ce_n=0 and adv_n=0 while no access is in progress. The word index is addr[4:1], so address bit 0 and the bits above bit 4 have no effect on where the word lands.
- R3: With LATENCY=2, the first data beat is sampled on the second rising edge after the address edge. Within each word the first beat is bits 15:0 and the second beat is bits 31:16.
- R4: While ce_n stays low, each further pair of beats is stored at the next word index, and index 15 is followed by index 0.
- R5: For every stored word, wr_done is high for exactly one cycle, in the cycle after the edge that sampled the word's second beat, and wr_idx then shows the word's index. No other cycle has wr_done high.
- R6: If ce_n goes high after an odd number of beats, the partial word is not written, the entry it was aimed at keeps its old value, and err_count rises by exactly 1.
- R7: While ce_n is high, the slave ignores adv_n, addr and data_in. No entry changes and wr_done stays low.
- R8: If ce_n goes high before the first data beat, nothing is written and err_count does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Continuous bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ce_n | input | 1 | Active-low chip select; low during a burst means write |
| adv_n | input | 1 | Active-low address-valid strobe |
| addr | input | 8 | Half-word address from the bus |
| data_in | input | 16 | Data bus |
| rd_idx | input | 4 | Register-file read index |
| rd_data | output | 32 | Content of entry rd_idx |
| wr_done | output | 1 | One-cycle pulse per stored word |
| wr_idx | output | 4 | Index of the word reported by wr_done |
| err_count | output | 8 | Count of bursts that ended on an odd beat |

## Verification
A single-word burst at an address with bit 0 set checks the latency and the order of the two half words. It also shows that bit 0 does not move the index. A three-word burst that starts at index 14 separates a slave that keeps pairing beats and wraps from one that stops after the first word or runs past the end of the file. Bursts of three beats and one beat check that a partial word is dropped and the error counter steps. A select that rises during the latency must leave the file and the counter alone. A stretch with the select high, while the strobe, address and data toggle, must not write anything.

// File: rtl/psram_wr_pkg.sv
package psram_wr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LAT  = 2'd1,
    ST_BEAT = 2'd2
  } seq_state_t;
endpackage

// File: rtl/psram_wr_seq.sv
module psram_wr_seq
  import psram_wr_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int IDX_W   = 4,
  parameter int LATENCY = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              adv_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              take_lo,
  output logic              commit,
  output logic              odd_abort,
  output logic [IDX_W-1:0]  idx
);
  localparam int LAT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;
  localparam logic [LAT_W-1:0] LAT_LOAD = LAT_W'(LATENCY - 1);

  seq_state_t       state_q, state_d;
  logic [LAT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             half_q, half_d;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    idx_d     = idx_q;
    half_d    = half_q;
    take_lo   = 1'b0;
    commit    = 1'b0;
    odd_abort = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (!ce_n && !adv_n) begin
          idx_d   = addr[IDX_W:1];
          cnt_d   = LAT_LOAD;
          half_d  = 1'b0;
          state_d = ST_LAT;
        end
      end
      ST_LAT: begin
        if (ce_n) begin
          state_d = ST_IDLE;
        end else if (cnt_q == '0) begin
          take_lo = 1'b1;
          half_d  = 1'b1;
          state_d = ST_BEAT;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_BEAT: begin
        if (ce_n) begin
          odd_abort = half_q;
          half_d    = 1'b0;
          state_d   = ST_IDLE;
        end else if (half_q) begin
          commit = 1'b1;
          idx_d  = idx_q + 1'b1;
          half_d = 1'b0;
        end else begin
          take_lo = 1'b1;
          half_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      half_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      half_q  <= half_d;
    end
  end

  assign idx = idx_q;

  assert_idx_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> idx_q == IDX_W'($past(idx_q) + 1'b1));
endmodule

// File: rtl/psram_wr_regfile.sv
module psram_wr_regfile #(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 32,
  parameter int HALF_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_lo,
  input  logic              commit,
  input  logic [IDX_W-1:0]  wr_sel,
  input  logic [HALF_W-1:0] data_in,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_data
);
  logic [HALF_W-1:0] lo_q;
  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0]  we_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lo_q <= '0;
    else if (take_lo) lo_q <= data_in;
  end

  assign word = {data_in, lo_q};

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    assign we_vec[g] = commit && (wr_sel == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mem_q[g] <= '0;
      else if (we_vec[g]) mem_q[g] <= word;
    end
  end

  assign rd_data = mem_q[rd_idx];

  assert_single_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(we_vec));
endmodule

// File: rtl/psram_wr_slave.sv
module psram_wr_slave #(
  parameter int ADDR_W  = 8,
  parameter int DEPTH   = 16,
  parameter int LATENCY = 2,
  parameter int ERR_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ce_n,
  input  logic                     adv_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [15:0]              data_in,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic [31:0]              rd_data,
  output logic                     wr_done,
  output logic [$clog2(DEPTH)-1:0] wr_idx,
  output logic [ERR_W-1:0]         err_count
);
  localparam int IDX_W = $clog2(DEPTH);

  logic             take_lo, commit, odd_abort;
  logic [IDX_W-1:0] idx;
  logic             done_q;
  logic [IDX_W-1:0] done_idx_q;
  logic [ERR_W-1:0] err_q;

  psram_wr_seq #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .LATENCY(LATENCY)) u_seq (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .adv_n(adv_n), .addr(addr),
    .take_lo(take_lo), .commit(commit), .odd_abort(odd_abort), .idx(idx)
  );

  psram_wr_regfile #(.DEPTH(DEPTH), .WORD_W(32), .HALF_W(16), .IDX_W(IDX_W)) u_rf (
    .clk(clk), .rst_n(rst_n), .take_lo(take_lo), .commit(commit),
    .wr_sel(idx), .data_in(data_in), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q     <= 1'b0;
      done_idx_q <= '0;
      err_q      <= '0;
    end else begin
      done_q <= commit;
      if (commit)    done_idx_q <= idx;
      if (odd_abort) err_q      <= err_q + 1'b1;
    end
  end

  assign wr_done   = done_q;
  assign wr_idx    = done_idx_q;
  assign err_count = err_q;

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !wr_done);

  assert_err_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count != $past(err_count)) |-> (err_count == ERR_W'($past(err_count) + 1'b1)));

  assert_no_write_ce_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !commit);
endmodule

// File: tb/psram_wr_slave_tb.sv
module psram_wr_slave_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ce_n, adv_n;
  logic [7:0]  addr;
  logic [15:0] data_in;
  logic [3:0]  rd_idx;
  logic [31:0] rd_data;
  logic        wr_done;
  logic [3:0]  wr_idx;
  logic [7:0]  err_count;

  int errors = 0;
  int checks = 0;
  int done_seen = 0;
  int exp_err = 0;
  int pat = 0;
  logic [31:0] exp_mem [16];
  logic [3:0]  exp_q [$];

  always #2.5 clk = ~clk;

  psram_wr_slave u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .adv_n(adv_n), .addr(addr),
    .data_in(data_in), .rd_idx(rd_idx), .rd_data(rd_data),
    .wr_done(wr_done), .wr_idx(wr_idx), .err_count(err_count)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every done pulse (R5)
  always @(negedge clk) begin
    if (rst_n === 1'b1 && wr_done === 1'b1) begin
      done_seen++;
      if (exp_q.size() == 0) begin
        check("R5 unexpected wr_done", 32'd1, 32'd0);
      end else begin
        check("R5 wr_idx order", 32'(wr_idx), 32'(exp_q.pop_front()));
      end
    end
  end

  task automatic burst(input logic [7:0] a, input int nbeats);
    logic [3:0]  i = a[4:1];
    logic [15:0] lo = '0;
    logic [15:0] v;
    @(negedge clk); ce_n = 1'b0; adv_n = 1'b0; addr = a;
    @(negedge clk); adv_n = 1'b1; data_in = 16'hDEAD; addr = ~a;
    for (int k = 0; k < nbeats; k++) begin
      pat++;
      v = 16'hA000 + 16'(pat);
      @(negedge clk); data_in = v;
      if (k % 2 == 1) begin
        exp_q.push_back(i);
        exp_mem[i] = {v, lo};
        i++;
      end else begin
        lo = v;
      end
    end
    @(negedge clk); ce_n = 1'b1; data_in = 16'h5A5A;
    if (nbeats % 2 == 1) exp_err++;
    repeat (3) @(negedge clk);
  endtask

  task automatic dump(input string req);
    for (int j = 0; j < 16; j++) begin
      rd_idx = 4'(j);
      #0.1;
      check(req, rd_data, exp_mem[j]);
    end
  endtask

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seen0;
    for (int j = 0; j < 16; j++) exp_mem[j] = '0;
    rst_n = 1'b0; ce_n = 1'b1; adv_n = 1'b1; addr = '0; data_in = '0; rd_idx = '0;
    repeat (3) @(negedge clk);
    check("R1 err_count in reset", 32'(err_count), 32'd0);
    check("R1 wr_done in reset", 32'(wr_done), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    dump("R1 register file after reset");

    // R2 R3: one word, addr bit 0 set -> index 2
    burst(8'h05, 2);
    check("R5 scoreboard drained", 32'(exp_q.size()), 32'd0);
    dump("R3 half-word order / R2 index");

    // R4: three words from index 14, wrapping to 0; upper addr bits ignored (R2)
    burst(8'hFC, 6);
    check("R4 all words reported", 32'(exp_q.size()), 32'd0);
    dump("R4 burst with wrap");

    // R6: three beats -> one word plus dropped half
    burst(8'h0A, 3);
    check("R6 err_count after odd end", 32'(err_count), 32'(exp_err));
    dump("R6 partial word discarded");

    // R6: single beat
    burst(8'h10, 1);
    check("R6 err_count after single beat", 32'(err_count), 32'(exp_err));
    dump("R6 single beat discarded");

    // R8: select rises during latency
    burst(8'h06, 0);
    check("R8 err_count unchanged", 32'(err_count), 32'(exp_err));
    dump("R8 no write on early abort");

    // R7: select high, other inputs toggling
    seen0 = done_seen;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      adv_n = k[0]; addr = 8'(k * 3); data_in = 16'(16'h7000 + k);
    end
    adv_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 no wr_done with ce_n high", 32'(done_seen), 32'(seen0));
    check("R7 err_count unchanged", 32'(err_count), 32'(exp_err));
    dump("R7 file unchanged with ce_n high");

    // back-to-back bursts still work after the idle stretch
    burst(8'h00, 4);
    check("R4 second burst reported", 32'(exp_q.size()), 32'd0);
    dump("R4 burst from index 0");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule